// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Sequencing

This block is an asynchronous serial transmitter. It takes bytes through a one-entry holding register, moves them into a shift register and sends each as a frame. A frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. An external baud tick marks the bit boundaries: the line moves one bit for each tick. The block does not generate the tick itself.

A line break is handled as a special character. A start-break pulse asks for a break. The line goes low once any character in the shift register has finished. A stop-break pulse asks for the break to end. The low level still lasts at least one full frame time. After that the line is held high for a recovery gap before any new frame goes out. Strict rules decide which commands and data writes are taken. A ready flag tells software when it may act, and an empty flag tells it when the line is quiet.

Top module: `uart_brk_tx`

## Requirements
- R1: A frame is one low start bit, then DATA_W data bits least significant first, then, when PARITY_EN=1, a parity bit (even parity, meaning XOR of the data, when PARITY_ODD=0; otherwise its inverse), then one high stop bit. Each bit lasts from one baud tick to the next. When nothing is being sent the line is high.
- R2: While tx_ready is 1, a wr_en pulse loads wr_data into the holding register, and tx_ready and tx_empty read 0 in the following cycle. A byte written while the previous frame is being sent starts right after that frame's stop bit, with no idle bit between the frames. After reset tx_ready is 1.
- R3: A brk_start pulse is accepted only when tx_ready is 1, no break is in progress and brk_stop is low. Once accepted, tx_ready reads 0 from the next cycle until the line has gone low.
- R4: A character already in the shift register when a break is accepted is sent completely. The line goes low directly after its stop bit.
- R5: The line stays low for at least FRAME_BITS = DATA_W+PARITY_EN+2 bit periods, even if brk_stop is accepted straight away. With an early stop request it stays low for exactly that long.
- R6: After the low level ends, the line stays high for at least IDLE_BITS bit periods before the next start bit or break.
- R7: A brk_stop with no break in progress has no effect. A brk_start and a brk_stop in the same cycle are both ignored.
- R8: A write made while the line is held low and no stop has been requested is discarded. It sets wr_err, and wr_err stays 1 until reset.
- R9: A write made while tx_ready is 0 is discarded. This includes a write while a break is requested but has not yet started.
- R10: tx_empty is 1 after reset. It is 0 from the start of a break through the end of the recovery gap. It returns to 1 only when no character is waiting or being sent.
- R11: A brk_start during a break or its recovery gap has no effect: tx_ready stays 1 and the low time does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| brk_start | input | 1 | Start-break command pulse |
| brk_stop | input | 1 | Stop-break command pulse |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register can take a write or command |
| tx_empty | output | 1 | Nothing waiting, sending, breaking or recovering |
| wr_err | output | 1 | Sticky flag: write discarded during an active break |

## Verification
The bench builds the block with eight data bits, even parity and a twelve-period recovery gap. This gives an eleven-bit frame, so the break minimum and the parity bit position can both be checked exactly on the recorded line. With a baud tick every four clocks, the bench can issue commands between ticks. It can therefore reach the case where brk_stop arrives in the first bit period of a break, which shows whether the minimum length is enforced. It can also try extra starts and discarded writes while the line is low.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

   typedef enum logic [2:0] {
      BRK_NONE = 3'd0,
      BRK_PEND = 3'd1,
      BRK_ON   = 3'd2,
      BRK_STOP = 3'd3,
      BRK_REC  = 3'd4
   } brk_st_t;

   function automatic int frame_len(input int dw, input int par);
      return dw + par + 2;
   endfunction

endpackage

// File: rtl/uart_brk_frame.sv
module uart_brk_frame #(
   parameter int DATA_W     = 8,
   parameter int PARITY_EN  = 1,
   parameter int PARITY_ODD = 0,
   localparam int FB = uart_brk_pkg::frame_len(DATA_W, PARITY_EN),
   localparam int CW = $clog2(FB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              last,
   output logic              bit_out
);

   logic [FB-1:0] frame_q;
   logic [FB-1:0] frame_ld;
   logic [CW-1:0] idx_q;
   logic          busy_q;

   generate
      if (PARITY_EN != 0) begin : g_par
         logic par_b;
         assign par_b    = (^data) ^ (PARITY_ODD != 0);
         assign frame_ld = {1'b1, par_b, data, 1'b0};
      end else begin : g_nopar
         assign frame_ld = {1'b1, data, 1'b0};
      end
   endgenerate

   assign last    = busy_q && (idx_q == CW'(FB - 1));
   assign busy    = busy_q;
   assign bit_out = frame_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '1;
         idx_q   <= '0;
         busy_q  <= 1'b0;
      end else if (load) begin
         frame_q <= frame_ld;
         idx_q   <= '0;
         busy_q  <= 1'b1;
      end else if (tick && busy_q) begin
         frame_q <= {1'b1, frame_q[FB-1:1]};
         idx_q   <= idx_q + 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_brk_seq.sv
module uart_brk_seq
   import uart_brk_pkg::*;
#(
   parameter int FRAME_BITS = 11,
   parameter int IDLE_BITS  = 12,
   localparam int MAXC = (FRAME_BITS > IDLE_BITS) ? FRAME_BITS : IDLE_BITS,
   localparam int CW   = $clog2(MAXC + 1)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    start_acc,
   input  logic    stop_acc,
   input  logic    line_free,
   output brk_st_t st
);

   brk_st_t       st_q;
   logic [CW-1:0] cnt_q;

   assign st = st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= BRK_NONE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            BRK_NONE: if (start_acc) st_q <= BRK_PEND;
            BRK_PEND: begin
               if (tick && line_free) begin
                  st_q  <= BRK_ON;
                  cnt_q <= '0;
               end
            end
            BRK_ON: begin
               if (tick && cnt_q != CW'(FRAME_BITS)) cnt_q <= cnt_q + 1'b1;
               if (stop_acc) st_q <= BRK_STOP;
            end
            BRK_STOP: begin
               if (tick) begin
                  if (cnt_q >= CW'(FRAME_BITS - 1)) begin
                     st_q  <= BRK_REC;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            BRK_REC: begin
               if (tick) begin
                  if (cnt_q == CW'(IDLE_BITS - 1)) begin
                     st_q  <= BRK_NONE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= BRK_NONE;
         endcase
      end
   end

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
   import uart_brk_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PARITY_EN  = 1,
   parameter int PARITY_ODD = 0,
   parameter int IDLE_BITS  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              brk_start,
   input  logic              brk_stop,
   output logic              txd,
   output logic              tx_ready,
   output logic              tx_empty,
   output logic              wr_err
);

   localparam int FRAME_BITS = frame_len(DATA_W, PARITY_EN);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_dw
         $error("uart_brk_tx: DATA_W must lie in 5..9");
      end
      if (PARITY_EN != 0 && PARITY_EN != 1) begin : g_bad_par
         $error("uart_brk_tx: PARITY_EN must be 0 or 1");
      end
      if (IDLE_BITS < 1) begin : g_bad_idle
         $error("uart_brk_tx: IDLE_BITS must be at least 1");
      end
   endgenerate

   brk_st_t           st;
   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;
   logic              wr_err_q;
   logic              sh_busy, sh_last, sh_bit, sh_free;
   logic              ready, load, start_acc, stop_acc, wr_take, brk_low;

   assign sh_free   = !sh_busy || sh_last;
   assign ready     = !hold_valid && (st != BRK_PEND);
   assign brk_low   = (st == BRK_ON) || (st == BRK_STOP);
   assign load      = baud_tick && sh_free && hold_valid &&
                      ((st == BRK_NONE) || (st == BRK_PEND));
   assign start_acc = brk_start && !brk_stop && ready && (st == BRK_NONE);
   assign stop_acc  = brk_stop && !brk_start && ready && (st == BRK_ON);
   assign wr_take   = wr_en && ready && (st != BRK_ON);

   uart_brk_frame #(
      .DATA_W    (DATA_W),
      .PARITY_EN (PARITY_EN),
      .PARITY_ODD(PARITY_ODD)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (baud_tick),
      .load   (load),
      .data   (hold_data),
      .busy   (sh_busy),
      .last   (sh_last),
      .bit_out(sh_bit)
   );

   uart_brk_seq #(
      .FRAME_BITS(FRAME_BITS),
      .IDLE_BITS (IDLE_BITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .start_acc(start_acc),
      .stop_acc (stop_acc),
      .line_free(sh_free && !hold_valid),
      .st       (st)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
         wr_err_q   <= 1'b0;
      end else begin
         if (load) begin
            hold_valid <= 1'b0;
         end else if (wr_take) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
         end
         if (wr_en && st == BRK_ON) wr_err_q <= 1'b1;
      end
   end

   assign txd      = brk_low ? 1'b0 : (sh_busy ? sh_bit : 1'b1);
   assign tx_ready = ready;
   assign tx_empty = !sh_busy && !hold_valid && ((st == BRK_NONE) || (st == BRK_PEND));
   assign wr_err   = wr_err_q;

endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk
   import uart_brk_pkg::*;
#(
   parameter int FRAME_BITS = 11,
   parameter int IDLE_BITS  = 12
) (
   input logic    clk,
   input logic    rst_n,
   input logic    baud_tick,
   input logic    wr_en,
   input logic    brk_start,
   input logic    brk_stop,
   input logic    txd,
   input logic    tx_ready,
   input logic    tx_empty,
   input logic    wr_err,
   input brk_st_t st
);

   logic [15:0] low_ticks;
   logic [15:0] hi_ticks;
   logic        after_brk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_ticks <= '0;
         hi_ticks  <= '0;
         after_brk <= 1'b0;
      end else begin
         if (st == BRK_NONE) low_ticks <= '0;
         else if (baud_tick && !txd && low_ticks != 16'hFFFF) low_ticks <= low_ticks + 1'b1;
         if (baud_tick) begin
            if (txd) begin
               if (hi_ticks != 16'hFFFF) hi_ticks <= hi_ticks + 1'b1;
            end else begin
               hi_ticks <= '0;
            end
         end
         if (st == BRK_REC) after_brk <= 1'b1;
         else if (baud_tick && !txd) after_brk <= 1'b0;
      end
   end

   p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_ready && st != BRK_ON) |=> (!tx_ready && !tx_empty));

   p_start_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_start && !brk_stop && tx_ready && st == BRK_NONE) |=> !tx_ready);

   p_break_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BRK_REC && $past(st) == BRK_STOP) |-> (low_ticks >= 16'(FRAME_BITS)));

   p_idle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(txd) && after_brk) |-> (hi_ticks >= 16'(IDLE_BITS)));

   p_lone_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_stop && !brk_start && st == BRK_NONE) |=> (st == BRK_NONE));

   p_both_cmds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_stop && brk_start && st == BRK_NONE) |=> (st == BRK_NONE));

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err);

endmodule

bind uart_brk_tx uart_brk_tx_chk #(
   .FRAME_BITS(FRAME_BITS),
   .IDLE_BITS (IDLE_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .baud_tick(baud_tick),
   .wr_en    (wr_en),
   .brk_start(brk_start),
   .brk_stop (brk_stop),
   .txd      (txd),
   .tx_ready (tx_ready),
   .tx_empty (tx_empty),
   .wr_err   (wr_err),
   .st       (st)
);

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int DW         = 8;
   localparam int IDLE       = 12;
   localparam int FB         = 11;
   localparam int WDOG       = 150000;
   localparam int HMAX       = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          baud_tick;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          brk_start = 1'b0;
   logic          brk_stop = 1'b0;
   logic          txd, tx_ready, tx_empty, wr_err;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int div;
   bit hist [HMAX];
   int nh = 0;

   uart_brk_tx #(.DATA_W(DW), .PARITY_EN(1), .PARITY_ODD(0), .IDLE_BITS(IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
      .brk_start(brk_start), .brk_stop(brk_stop), .txd(txd), .tx_ready(tx_ready),
      .tx_empty(tx_empty), .wr_err(wr_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         div <= 0;
         baud_tick <= 1'b0;
      end else begin
         div <= (div == TICK_DIV - 1) ? 0 : div + 1;
         baud_tick <= (div == TICK_DIV - 1);
      end
   end

   always @(negedge clk) begin
      if (rst_n && baud_tick && nh < HMAX) begin
         hist[nh] = txd;
         nh = nh + 1;
      end
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > WDOG) begin
         checks = checks + 1;
         fails = fails + 1;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, WDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_bit(input logic [DW-1:0] d, input int i);
      if (i == 0) return 1'b0;
      if (i <= DW) return d[i-1];
      if (i == DW + 1) return ^d;
      return 1'b1;
   endfunction

   function automatic int find_low(input int from);
      for (int i = from; i < nh; i++) if (hist[i] == 1'b0) return i;
      return -1;
   endfunction

   function automatic int run_len(input int from, input bit v);
      int n = 0;
      if (from < 0) return 0;
      while (from + n < nh && hist[from + n] == v) n++;
      return n;
   endfunction

   function automatic int frame_err(input int at, input logic [DW-1:0] d);
      int e = 0;
      if (at < 0 || at + FB > nh) return FB;
      for (int i = 0; i < FB; i++) if (hist[at + i] != exp_bit(d, i)) e++;
      return e;
   endfunction

   task automatic wait_ticks(input int n);
      int t = nh + n;
      while (nh < t) @(negedge clk);
   endtask

   task automatic wait_ready();
      while (!tx_ready) @(negedge clk);
   endtask

   task automatic wait_empty();
      while (!tx_empty) @(negedge clk);
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input bit st_b, input bit sp_b);
      @(negedge clk);
      brk_start = st_b;
      brk_stop = sp_b;
      @(negedge clk);
      brk_start = 1'b0;
      brk_stop = 1'b0;
   endtask

   initial begin
      int base, s, z, o, seed_dummy;
      logic [DW-1:0] d, d2;
      seed_dummy = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(txd == 1'b1, "R1 reset line", txd, 1);
      chk(tx_ready == 1'b1, "R2 reset ready", tx_ready, 1);
      chk(tx_empty == 1'b1, "R10 reset empty", tx_empty, 1);
      chk(wr_err == 1'b0, "R8 reset err", wr_err, 0);

      // R1/R2: single frames, directed and random bytes
      for (int k = 0; k < 6; k++) begin
         d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : DW'($urandom);
         wait_empty();
         base = nh;
         do_write(d);
         chk(tx_ready == 1'b0, "R2 ready low after write", tx_ready, 0);
         wait_empty();
         wait_ticks(2);
         s = find_low(base);
         chk(frame_err(s, d) == 0, "R1 frame bits", frame_err(s, d), 0);
      end

      // R2: back-to-back frames without a gap
      d = DW'($urandom);
      d2 = DW'($urandom);
      wait_empty();
      base = nh;
      do_write(d);
      wait_ready();
      do_write(d2);
      wait_empty();
      wait_ticks(2);
      s = find_low(base);
      chk(frame_err(s, d) == 0, "R2 first of pair", frame_err(s, d), 0);
      chk(frame_err(s + FB, d2) == 0, "R2 second contiguous", frame_err(s + FB, d2), 0);

      // R3/R4/R5/R6/R9/R10: break behind a character, early stop
      d = 8'hA5;
      d2 = 8'h3C;
      wait_empty();
      base = nh;
      do_write(d);
      wait_ready();
      pulse(1'b1, 1'b0);
      chk(tx_ready == 1'b0, "R3 ready low while pending", tx_ready, 0);
      do_write(8'h77);
      chk(tx_ready == 1'b0, "R9 pending write ignored", tx_ready, 0);
      wait_ready();
      chk(txd == 1'b0, "R3 line low when ready returns", txd, 0);
      chk(tx_empty == 1'b0, "R10 empty low in break", tx_empty, 0);
      pulse(1'b0, 1'b1);
      while (!txd) @(negedge clk);
      chk(tx_empty == 1'b0, "R10 empty low in recovery", tx_empty, 0);
      wait_empty();
      do_write(d2);
      wait_empty();
      wait_ticks(2);
      s = find_low(base);
      chk(frame_err(s, d) == 0, "R4 character finished first", frame_err(s, d), 0);
      z = run_len(s + FB, 1'b0);
      chk(z == FB, "R5 minimum break length", z, FB);
      o = run_len(s + FB + z, 1'b1);
      chk(o >= IDLE, "R6 recovery high time", o, IDLE);
      chk(frame_err(s + FB + z + o, d2) == 0, "R9 next frame is the later byte",
          frame_err(s + FB + z + o, d2), 0);

      // R8/R11: write and extra start during active break
      wait_empty();
      base = nh;
      pulse(1'b1, 1'b0);
      wait_ready();
      chk(txd == 1'b0, "R3 break started from idle", txd, 0);
      do_write(8'h5A);
      chk(wr_err == 1'b1, "R8 error flag set", wr_err, 1);
      chk(tx_ready == 1'b1, "R8 ready stays high", tx_ready, 1);
      pulse(1'b1, 1'b0);
      chk(tx_ready == 1'b1, "R11 extra start ignored", tx_ready, 1);
      wait_ticks(3);
      pulse(1'b0, 1'b1);
      wait_empty();
      wait_ticks(4);
      s = find_low(base);
      z = run_len(s, 1'b0);
      chk(z == FB, "R11 break length unchanged", z, FB);
      o = run_len(s + z, 1'b1);
      chk(o == nh - (s + z), "R8 discarded byte never sent", o, nh - (s + z));
      chk(wr_err == 1'b1, "R8 error flag sticky", wr_err, 1);

      // R7: lone stop and simultaneous commands
      wait_empty();
      base = nh;
      pulse(1'b0, 1'b1);
      chk(tx_ready == 1'b1 && tx_empty == 1'b1, "R7 lone stop ignored",
          {tx_ready, tx_empty}, 3);
      pulse(1'b1, 1'b1);
      chk(tx_ready == 1'b1, "R7 simultaneous commands ignored", tx_ready, 1);
      wait_ticks(FB + 2);
      chk(find_low(base) == -1, "R7 line stayed high", find_low(base), -1);
      chk(tx_empty == 1'b1, "R10 empty after ignored commands", tx_empty, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule